// File: doc/BRIEF.md
# Pauli Frame Tracker and Instruction Router

This block sits between a quantum instruction decoder and the physical execution stage. It keeps a two-bit X/Z error record for every data qubit in classical flip-flops, so Pauli errors are tracked rather than corrected on the qubits. Each incoming instruction carries an opcode, a target qubit and a second qubit (used by the two-qubit gate). A per-qubit type vector marks each qubit as data or ancilla. The block decides, from the gate class and the qubit type, whether the instruction updates the frame, goes downstream, or both.

Before a non-Clifford gate on a data qubit, the block replays the stored record as explicit X and Z correction gates. It then forwards the gate itself and clears the record. Measurement results that come back from the execution stage are corrected using the measured qubit's record, and that record is then cleared. The downstream instruction stream uses a valid/ready handshake. It is held by one output register, and the input stalls while corrections are still being injected.

Top module: `pauli_frame_tracker`

## Requirements
- R1: After reset, `out_valid` and `meas_out_valid` are 0, `in_ready` is 1 and every frame record is zero, so a data-qubit measurement result is returned unchanged.
- R2: Opcodes are 0=X, 1=Y, 2=Z, 3=H, 4=S, 5=CNOT, 6=T, 7=MEAS. `qtype[i]`=1 marks qubit i as ancilla, and any index at or above NQ counts as ancilla. An instruction whose first qubit is ancilla, or a CNOT whose second qubit is ancilla, is forwarded unchanged and leaves every record untouched.
- R3: A Pauli gate (X, Y, Z) on a data qubit produces no downstream instruction. X toggles the qubit's x bit, Z toggles its z bit, and Y toggles both.
- R4: H and S on a data qubit are forwarded unchanged. H swaps the x and z bits. S sets z to z XOR x.
- R5: A CNOT between two data qubits (control = first qubit, target = second qubit) is forwarded unchanged. The target's x bit becomes x_t XOR x_c, and the control's z bit becomes z_c XOR z_t.
- R6: A T gate on a data qubit is preceded downstream by X on that qubit if its x bit is set, then Z if its z bit is set. Correction instructions carry second qubit 0. The T follows unchanged, and the record is cleared.
- R7: While injected corrections for a T gate are still pending, `in_ready` is 0.
- R8: Every instruction not consumed by R3 is forwarded downstream, including MEAS. A returned measurement appears on `meas_out_*` one cycle after `meas_in_valid`, with the same qubit index. For a data qubit the bit is inverted when the x bit is set; for an ancilla it is passed unchanged.
- R9: Once a data-qubit measurement result has been returned, both record bits of that qubit are zero.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output instruction holds steady.
- R11: An instruction that is forwarded and accepted with the output slot free appears on `out_*` in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qtype | input | NQ | Qubit type table, 1 = ancilla |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_op | input | 3 | Instruction opcode |
| in_q0 | input | QW | First qubit (target, or control for CNOT) |
| in_q1 | input | QW | Second qubit (CNOT target) |
| out_valid | output | 1 | Downstream instruction present |
| out_ready | input | 1 | Downstream accepts |
| out_op | output | 3 | Downstream opcode |
| out_q0 | output | QW | Downstream first qubit |
| out_q1 | output | QW | Downstream second qubit |
| meas_in_valid | input | 1 | Raw measurement result valid |
| meas_in_q | input | QW | Measured qubit |
| meas_in_bit | input | 1 | Raw measurement bit |
| meas_out_valid | output | 1 | Translated result valid |
| meas_out_q | output | QW | Translated result qubit |
| meas_out_bit | output | 1 | Translated measurement bit |

## Verification
A forwarded instruction is due on the output one cycle after its accepting edge. Each injected correction and the trailing T take one further cycle per free output slot. A translated measurement is due exactly one cycle after its raw result. The bench drives inputs and the ready line on the falling edge and samples outputs there as well. It predicts the frame at the moment of acceptance and compares each downstream transfer, in order, against a queue of expected instructions. Hold and stall behaviour is checked with the output deliberately blocked for several cycles.

// File: rtl/pft_pkg.sv
package pft_pkg;

    typedef enum logic [2:0] {
        OP_X    = 3'd0,
        OP_Y    = 3'd1,
        OP_Z    = 3'd2,
        OP_H    = 3'd3,
        OP_S    = 3'd4,
        OP_CNOT = 3'd5,
        OP_T    = 3'd6,
        OP_MEAS = 3'd7
    } pft_op_e;

    typedef enum logic [2:0] {
        RT_RAW      = 3'd0,
        RT_PAULI    = 3'd1,
        RT_CLIFF    = 3'd2,
        RT_NONCLIFF = 3'd3,
        RT_MEAS     = 3'd4
    } pft_route_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT_Z = 2'd1,
        ST_EMIT_T = 2'd2
    } pft_state_e;

endpackage

// File: rtl/pft_anc_map.sv
module pft_anc_map #(
    parameter int NQ   = 17,
    parameter int PADW = 32
) (
    input  logic [NQ-1:0]   qtype,
    output logic [PADW-1:0] anc
);
    // Slots beyond the physical qubit count behave as ancillas: never tracked.
    for (genvar i = 0; i < PADW; i++) begin : g_slot
        if (i < NQ) begin : g_real
            assign anc[i] = qtype[i];
        end else begin : g_pad
            assign anc[i] = 1'b1;
        end
    end
endmodule

// File: rtl/pft_route_decode.sv
module pft_route_decode
    import pft_pkg::*;
#(
    parameter int QW   = 5,
    parameter int PADW = 32
) (
    input  logic [2:0]      op,
    input  logic [QW-1:0]   q0,
    input  logic [QW-1:0]   q1,
    input  logic [PADW-1:0] anc,
    output pft_route_e      route
);
    logic touches_anc;

    always_comb begin
        touches_anc = anc[q0] || ((pft_op_e'(op) == OP_CNOT) && anc[q1]);
        if (touches_anc) begin
            route = RT_RAW;
        end else begin
            case (pft_op_e'(op))
                OP_X, OP_Y, OP_Z:     route = RT_PAULI;
                OP_H, OP_S, OP_CNOT:  route = RT_CLIFF;
                OP_T:                 route = RT_NONCLIFF;
                default:              route = RT_MEAS;
            endcase
        end
    end
endmodule

// File: rtl/pft_frame.sv
module pft_frame
    import pft_pkg::*;
#(
    parameter int QW   = 5,
    parameter int PADW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_en,
    input  logic [2:0]      upd_op,
    input  logic [QW-1:0]   upd_q0,
    input  logic [QW-1:0]   upd_q1,
    input  logic            gate_clr_en,
    input  logic [QW-1:0]   gate_clr_q,
    input  logic            meas_clr_en,
    input  logic [QW-1:0]   meas_clr_q,
    output logic [PADW-1:0] rec_x,
    output logic [PADW-1:0] rec_z
);
    typedef struct packed {
        logic [PADW-1:0] x;
        logic [PADW-1:0] z;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (upd_en) begin
            case (pft_op_e'(upd_op))
                OP_X: f_d.x[upd_q0] = ~f_q.x[upd_q0];
                OP_Z: f_d.z[upd_q0] = ~f_q.z[upd_q0];
                OP_Y: begin
                    f_d.x[upd_q0] = ~f_q.x[upd_q0];
                    f_d.z[upd_q0] = ~f_q.z[upd_q0];
                end
                OP_H: begin
                    f_d.x[upd_q0] = f_q.z[upd_q0];
                    f_d.z[upd_q0] = f_q.x[upd_q0];
                end
                OP_S: f_d.z[upd_q0] = f_q.z[upd_q0] ^ f_q.x[upd_q0];
                OP_CNOT: begin
                    f_d.x[upd_q1] = f_q.x[upd_q1] ^ f_q.x[upd_q0];
                    f_d.z[upd_q0] = f_q.z[upd_q0] ^ f_q.z[upd_q1];
                end
                default: ;
            endcase
        end
        if (gate_clr_en) begin
            f_d.x[gate_clr_q] = 1'b0;
            f_d.z[gate_clr_q] = 1'b0;
        end
        // A returned measurement wins over a same-cycle gate update.
        if (meas_clr_en) begin
            f_d.x[meas_clr_q] = 1'b0;
            f_d.z[meas_clr_q] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rec_x = f_q.x;
    assign rec_z = f_q.z;
endmodule

// File: rtl/pft_meas_xlate.sv
module pft_meas_xlate #(
    parameter int QW   = 5,
    parameter int PADW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mi_valid,
    input  logic [QW-1:0]   mi_q,
    input  logic            mi_bit,
    input  logic [PADW-1:0] anc,
    input  logic [PADW-1:0] rec_x,
    output logic            mo_valid,
    output logic [QW-1:0]   mo_q,
    output logic            mo_bit,
    output logic            clr_en,
    output logic [QW-1:0]   clr_q
);
    typedef struct packed {
        logic          valid;
        logic [QW-1:0] q;
        logic          b;
    } mres_t;

    mres_t m_d, m_q;
    logic  flip;

    always_comb begin
        flip    = rec_x[mi_q] & ~anc[mi_q];
        m_d     = m_q;
        m_d.valid = mi_valid;
        if (mi_valid) begin
            m_d.q = mi_q;
            m_d.b = mi_bit ^ flip;
        end
        clr_en = mi_valid & ~anc[mi_q];
        clr_q  = mi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign mo_valid = m_q.valid;
    assign mo_q     = m_q.q;
    assign mo_bit   = m_q.b;
endmodule

// File: rtl/pauli_frame_tracker.sv
module pauli_frame_tracker
    import pft_pkg::*;
#(
    parameter int  NQ   = 17,
    localparam int QW   = $clog2(NQ),
    localparam int PADW = 1 << QW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] qtype,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [QW-1:0] in_q0,
    input  logic [QW-1:0] in_q1,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [2:0]    out_op,
    output logic [QW-1:0] out_q0,
    output logic [QW-1:0] out_q1,
    input  logic          meas_in_valid,
    input  logic [QW-1:0] meas_in_q,
    input  logic          meas_in_bit,
    output logic          meas_out_valid,
    output logic [QW-1:0] meas_out_q,
    output logic          meas_out_bit
);
    typedef struct packed {
        pft_state_e    st;
        logic          ov;
        logic [2:0]    op;
        logic [QW-1:0] q0;
        logic [QW-1:0] q1;
        logic [QW-1:0] hq;
        logic [QW-1:0] hq1;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, ov: 1'b0, op: 3'd0,
                                 q0: '0, q1: '0, hq: '0, hq1: '0};

    ctl_t            s_d, s_q;
    logic [PADW-1:0] anc;
    logic [PADW-1:0] fx, fz;
    pft_route_e      route;
    logic            slot_free, acc;
    logic            upd_en, tclr_en;
    logic            mclr_en;
    logic [QW-1:0]   mclr_q;

    pft_anc_map #(.NQ(NQ), .PADW(PADW)) anc_i (
        .qtype (qtype),
        .anc   (anc)
    );

    pft_route_decode #(.QW(QW), .PADW(PADW)) dec_i (
        .op    (in_op),
        .q0    (in_q0),
        .q1    (in_q1),
        .anc   (anc),
        .route (route)
    );

    pft_frame #(.QW(QW), .PADW(PADW)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (upd_en),
        .upd_op      (in_op),
        .upd_q0      (in_q0),
        .upd_q1      (in_q1),
        .gate_clr_en (tclr_en),
        .gate_clr_q  (in_q0),
        .meas_clr_en (mclr_en),
        .meas_clr_q  (mclr_q),
        .rec_x       (fx),
        .rec_z       (fz)
    );

    pft_meas_xlate #(.QW(QW), .PADW(PADW)) meas_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mi_valid (meas_in_valid),
        .mi_q     (meas_in_q),
        .mi_bit   (meas_in_bit),
        .anc      (anc),
        .rec_x    (fx),
        .mo_valid (meas_out_valid),
        .mo_q     (meas_out_q),
        .mo_bit   (meas_out_bit),
        .clr_en   (mclr_en),
        .clr_q    (mclr_q)
    );

    assign slot_free = !s_q.ov || out_ready;
    assign in_ready  = (s_q.st == ST_IDLE) && slot_free;
    assign acc       = in_valid && in_ready;

    always_comb begin
        s_d     = s_q;
        upd_en  = 1'b0;
        tclr_en = 1'b0;
        if (s_q.ov && out_ready) s_d.ov = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (acc) begin
                    case (route)
                        RT_PAULI: upd_en = 1'b1;
                        RT_NONCLIFF: begin
                            tclr_en = 1'b1;
                            s_d.hq  = in_q0;
                            s_d.hq1 = in_q1;
                            s_d.ov  = 1'b1;
                            if (fx[in_q0]) begin
                                s_d.op = OP_X;
                                s_d.q0 = in_q0;
                                s_d.q1 = '0;
                                s_d.st = fz[in_q0] ? ST_EMIT_Z : ST_EMIT_T;
                            end else if (fz[in_q0]) begin
                                s_d.op = OP_Z;
                                s_d.q0 = in_q0;
                                s_d.q1 = '0;
                                s_d.st = ST_EMIT_T;
                            end else begin
                                s_d.op = in_op;
                                s_d.q0 = in_q0;
                                s_d.q1 = in_q1;
                            end
                        end
                        default: begin
                            upd_en = (route == RT_CLIFF);
                            s_d.ov = 1'b1;
                            s_d.op = in_op;
                            s_d.q0 = in_q0;
                            s_d.q1 = in_q1;
                        end
                    endcase
                end
            end
            ST_EMIT_Z: begin
                if (slot_free) begin
                    s_d.ov = 1'b1;
                    s_d.op = OP_Z;
                    s_d.q0 = s_q.hq;
                    s_d.q1 = '0;
                    s_d.st = ST_EMIT_T;
                end
            end
            default: begin
                if (slot_free) begin
                    s_d.ov = 1'b1;
                    s_d.op = OP_T;
                    s_d.q0 = s_q.hq;
                    s_d.q1 = s_q.hq1;
                    s_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTL_RST;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_op    = s_q.op;
    assign out_q0    = s_q.q0;
    assign out_q1    = s_q.q1;
endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
    parameter int  NQ   = 17,
    localparam int QW   = $clog2(NQ),
    localparam int PADW = 1 << QW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NQ-1:0]   qtype,
    input logic            in_valid,
    input logic            in_ready,
    input logic [2:0]      in_op,
    input logic [QW-1:0]   in_q0,
    input logic [QW-1:0]   in_q1,
    input logic            out_valid,
    input logic            out_ready,
    input logic [2:0]      out_op,
    input logic [QW-1:0]   out_q0,
    input logic [QW-1:0]   out_q1,
    input logic            meas_in_valid,
    input logic [QW-1:0]   meas_in_q,
    input logic            meas_out_valid,
    input logic [QW-1:0]   meas_out_q,
    input logic [PADW-1:0] frame_x,
    input logic [PADW-1:0] frame_z
);
    logic [PADW-1:0] is_anc;
    logic            take, bypass, is_pauli, is_t;

    for (genvar i = 0; i < PADW; i++) begin : g_chk_anc
        if (i < NQ) begin : g_real
            assign is_anc[i] = qtype[i];
        end else begin : g_pad
            assign is_anc[i] = 1'b1;
        end
    end

    assign take     = in_valid && in_ready;
    assign bypass   = is_anc[in_q0] || (in_op == 3'd5 && is_anc[in_q1]);
    assign is_pauli = (in_op == 3'd0) || (in_op == 3'd1) || (in_op == 3'd2);
    assign is_t     = (in_op == 3'd6);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_op)
                                    && $stable(out_q0) && $stable(out_q1));

    // R2
    bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && bypass |=> out_valid && out_op == $past(in_op)
                           && out_q0 == $past(in_q0) && out_q1 == $past(in_q1));

    // R3
    pauli_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bypass && is_pauli |=> !out_valid);

    // R6
    t_first_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bypass && is_t && frame_x[in_q0]
        |=> out_valid && out_op == 3'd0 && out_q0 == $past(in_q0));

    // R6
    t_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bypass && is_t
        |=> !frame_x[$past(in_q0)] && !frame_z[$past(in_q0)]);

    // R7
    inject_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bypass && is_t && (frame_x[in_q0] || frame_z[in_q0]) |=> !in_ready);

    // R8
    meas_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_in_valid |=> meas_out_valid && meas_out_q == $past(meas_in_q));

    // R9
    meas_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_in_valid && !is_anc[meas_in_q]
        |=> !frame_x[$past(meas_in_q)] && !frame_z[$past(meas_in_q)]);
endmodule

bind pauli_frame_tracker pft_checker #(.NQ(NQ)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .qtype          (qtype),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_op          (in_op),
    .in_q0          (in_q0),
    .in_q1          (in_q1),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_op         (out_op),
    .out_q0         (out_q0),
    .out_q1         (out_q1),
    .meas_in_valid  (meas_in_valid),
    .meas_in_q      (meas_in_q),
    .meas_out_valid (meas_out_valid),
    .meas_out_q     (meas_out_q),
    .frame_x        (fx),
    .frame_z        (fz)
);

// File: tb/pauli_frame_tracker_tb_top.sv
module pauli_frame_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 17;
    localparam int QW = $clog2(NQ);

    localparam logic [2:0] C_X = 3'd0, C_Y = 3'd1, C_Z = 3'd2, C_H = 3'd3,
                           C_S = 3'd4, C_CX = 3'd5, C_T = 3'd6, C_M = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ-1:0] qtype = 17'h1FE00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_op = '0;
    logic [QW-1:0] in_q0 = '0, in_q1 = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2:0]    out_op;
    logic [QW-1:0] out_q0, out_q1;
    logic          meas_in_valid = 1'b0;
    logic [QW-1:0] meas_in_q = '0;
    logic          meas_in_bit = 1'b0;
    logic          meas_out_valid;
    logic [QW-1:0] meas_out_q;
    logic          meas_out_bit;

    pauli_frame_tracker #(.NQ(NQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .qtype(qtype),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
        .in_q0(in_q0), .in_q1(in_q1),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_q0(out_q0), .out_q1(out_q1),
        .meas_in_valid(meas_in_valid), .meas_in_q(meas_in_q),
        .meas_in_bit(meas_in_bit),
        .meas_out_valid(meas_out_valid), .meas_out_q(meas_out_q),
        .meas_out_bit(meas_out_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [2:0]    op;
        logic [QW-1:0] q0;
        logic [QW-1:0] q1;
        string         tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] mx = '0, mz = '0;
    int          checks = 0, errors = 0;
    int          rdy_mode = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_anc(input logic [QW-1:0] q);
        if (int'(q) >= NQ) return 1'b1;
        return qtype[q];
    endfunction

    task automatic push(input logic [2:0] op, input logic [QW-1:0] q0,
                        input logic [QW-1:0] q1, input string tag);
        exp_t e;
        e.op = op; e.q0 = q0; e.q1 = q1; e.tag = tag;
        expq.push_back(e);
    endtask

    // Frame prediction at the moment an instruction is accepted.
    task automatic model(input logic [2:0] op, input logic [QW-1:0] q0,
                         input logic [QW-1:0] q1);
        if (is_anc(q0) || (op == C_CX && is_anc(q1))) begin
            push(op, q0, q1, "R2");
        end else begin
            case (op)
                C_X: mx[q0] = ~mx[q0];
                C_Z: mz[q0] = ~mz[q0];
                C_Y: begin mx[q0] = ~mx[q0]; mz[q0] = ~mz[q0]; end
                C_H: begin
                    logic t;
                    push(op, q0, q1, "R4");
                    t = mx[q0]; mx[q0] = mz[q0]; mz[q0] = t;
                end
                C_S: begin push(op, q0, q1, "R4"); mz[q0] = mz[q0] ^ mx[q0]; end
                C_CX: begin
                    push(op, q0, q1, "R5");
                    mx[q1] = mx[q1] ^ mx[q0];
                    mz[q0] = mz[q0] ^ mz[q1];
                end
                C_T: begin
                    if (mx[q0]) push(C_X, q0, '0, "R6");
                    if (mz[q0]) push(C_Z, q0, '0, "R6");
                    push(C_T, q0, q1, "R6");
                    mx[q0] = 1'b0; mz[q0] = 1'b0;
                end
                default: push(op, q0, q1, "R8");
            endcase
        end
    endtask

    // Output monitor: choose ready, then compare the transfer due at the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            case (rdy_mode)
                0: out_ready = ($urandom_range(0, 3) != 0);
                1: out_ready = 1'b1;
                default: out_ready = 1'b0;
            endcase
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected output op", int'(out_op), 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(out_op == e.op, e.tag, "out_op", int'(out_op), int'(e.op));
                    chk(out_q0 == e.q0 && out_q1 == e.q1, e.tag, "out qubits",
                        int'({out_q0, out_q1}), int'({e.q0, e.q1}));
                end
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [QW-1:0] q0,
                        input logic [QW-1:0] q1);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_q0 = q0; in_q1 = q1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        model(op, q0, q1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic ret_meas(input logic [QW-1:0] q, input logic b);
        logic e;
        @(negedge clk);
        meas_in_valid = 1'b1; meas_in_q = q; meas_in_bit = b;
        e = is_anc(q) ? b : (b ^ mx[q]);
        @(posedge clk);
        #1;
        meas_in_valid = 1'b0;
        @(negedge clk);
        chk(meas_out_valid && meas_out_q == q, "R8", "meas valid/qubit",
            int'({meas_out_valid, meas_out_q}), int'({1'b1, q}));
        chk(meas_out_bit == e, "R8", "translated bit", int'(meas_out_bit), int'(e));
        if (!is_anc(q)) begin mx[q] = 1'b0; mz[q] = 1'b0; end
    endtask

    task automatic drain();
        int n = 0;
        while ((expq.size() != 0 || out_valid) && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R2", "pending expected outputs", expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: idle outputs and empty frame after reset
        chk(!out_valid, "R1", "out_valid", int'(out_valid), 0);
        chk(!meas_out_valid, "R1", "meas_out_valid", int'(meas_out_valid), 0);
        chk(in_ready, "R1", "in_ready", int'(in_ready), 1);
        ret_meas(5'd1, 1'b1);              // R1: untouched record passes bit
        send(C_T, 5'd3, 5'd0);             // R1: only the T leaves
        drain();

        // R3: Pauli gate on data is silent
        send(C_X, 5'd2, 5'd0);
        @(negedge clk);
        chk(!out_valid, "R3", "out_valid after Pauli", int'(out_valid), 0);
        send(C_T, 5'd2, 5'd4);             // reveals x=1: X then T
        drain();

        // R11: one-cycle forwarding latency
        send(C_H, 5'd4, 5'd9);
        @(negedge clk);
        chk(out_valid && out_op == C_H, "R11", "forward next cycle",
            int'({out_valid, out_op}), int'({1'b1, C_H}));
        drain();

        // R7, R10: blocked output while corrections are pending
        send(C_Y, 5'd5, 5'd0);
        rdy_mode = 2;
        send(C_T, 5'd5, 5'd7);
        @(negedge clk);
        #1;
        chk(out_valid && out_op == C_X, "R6", "first correction",
            int'({out_valid, out_op}), int'({1'b1, C_X}));
        chk(!in_ready, "R7", "in_ready during injection", int'(in_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid && out_op == C_X && out_q0 == 5'd5, "R10", "held output",
            int'({out_valid, out_op, out_q0}), int'({1'b1, C_X, 5'd5}));
        chk(!in_ready, "R7", "in_ready still low", int'(in_ready), 0);
        rdy_mode = 1;
        drain();

        // R5: CNOT propagation
        send(C_X, 5'd0, 5'd0);
        send(C_Z, 5'd1, 5'd0);
        send(C_CX, 5'd0, 5'd1);
        send(C_T, 5'd1, 5'd0);
        send(C_T, 5'd0, 5'd0);
        drain();

        // R4: H swaps, S folds x into z
        send(C_X, 5'd6, 5'd0);
        send(C_H, 5'd6, 5'd0);
        send(C_T, 5'd6, 5'd0);
        send(C_X, 5'd7, 5'd0);
        send(C_S, 5'd7, 5'd0);
        send(C_T, 5'd7, 5'd0);
        drain();

        // R8, R9: translation and clearing
        send(C_Y, 5'd8, 5'd0);
        send(C_M, 5'd8, 5'd0);
        ret_meas(5'd8, 1'b0);
        send(C_T, 5'd8, 5'd0);             // R9: nothing left to inject
        send(C_M, 5'd10, 5'd0);
        ret_meas(5'd10, 1'b1);             // ancilla passes unchanged
        drain();

        // R2: ancilla and out-of-range traffic bypasses the frame
        send(C_X, 5'd12, 5'd0);
        send(C_X, 5'd3, 5'd0);
        send(C_CX, 5'd3, 5'd11);
        send(C_H, 5'd20, 5'd2);
        send(C_T, 5'd3, 5'd0);
        drain();

        // Random mix
        rdy_mode = 0;
        for (int i = 0; i < 400; i++) begin
            logic [2:0]    op;
            logic [QW-1:0] a, b;
            op = 3'($urandom_range(0, 7));
            a  = QW'($urandom_range(0, 19));
            b  = QW'($urandom_range(0, NQ - 1));
            if (op == C_CX && a == b) b = (b == QW'(0)) ? QW'(1) : QW'(0);
            send(op, a, b);
            if (op == C_M) ret_meas(a, 1'($urandom_range(0, 1)));
        end
        rdy_mode = 1;
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule